// File: doc/BRIEF.md
# Accelerator Control Register Interface

This block is the register front end of a CPU accelerator card that sits on an 8-bit host bus. The host drives a 16-bit address, write data, a read strobe and a write strobe. Some locations are action strobes: a write there does something, and the data byte is ignored. These strobes pick the software speed, open or close the hardware register group, and choose one of four memory optimization modes.

A second group of locations forms the hardware registers. They can always be read. They accept writes only while the hardware-register-enable latch is set. The block combines its internal state with three external inputs: the speed switch, the disk-ROM switch and the host fast bit. From these it drives a speed selection code, which the clock logic turns into a 1 MHz, 2 MHz or turbo clock. The speed switch takes priority over any software turbo request.

Read data is combinational. While the read strobe is high, it shows the addressed register. At all other times it is zero. Writes update the state on the clock edge where the write strobe is sampled high, and the outputs show the new state from that cycle on.

Top module: `accel_ctl_regs`

## Requirements
- R1: After reset the enable latch is clear, the software speed flag is turbo, the system slow flag is clear and the optimization mode is 2'b11 (no optimization).
- R2: A write of any data byte to 16'hD07A sets the software speed flag to normal.
- R3: A write of any data byte to 16'hD07B or 16'hD079 sets the software speed flag to turbo.
- R4: The speed strobes of R2 and R3 take effect whether the enable latch is set or clear.
- R5: A write to 16'hD07E sets the enable latch. A write to 16'hD07F or 16'hD07D clears it. The latch is driven on output `hwreg_en`.
- R6: While the enable latch is set, a write to 16'hD074, D075, D076 or D077 sets `opt_mode` to 2'b00, 01, 10 or 11 respectively. While the latch is clear, these writes are ignored.
- R7: Normal speed is forced when the software flag is normal, or the speed switch input is 1, or the system slow flag is set. In that case `speed_sel` is {1'b0, host_fast}. Otherwise `speed_sel` is 2'b10 (turbo).
- R8: Reading 16'hD0B2 returns bit 7 = enable latch and bit 6 = system slow flag. A write to it loads the slow flag from data bit 6, but only while the latch is set.
- R9: Reading 16'hD0B4 returns the optimization mode in bits 7:6. A write to it loads the mode from data bits 7:6, but only while the latch is set.
- R10: Reading 16'hD0B5 returns bit 7 = disk-ROM switch and bit 6 = speed switch (1 = normal). Writes to it have no effect at any time.
- R11: Reading 16'hD0B8 returns bit 7 = software speed flag (1 = normal) and bit 6 = the forced-normal condition of R7. A write to it loads the software flag from data bit 7, but only while the latch is set.
- R12: Reading 16'hD0B0 returns 2'b00 in bits 7:6 in 128 mode and 2'b01 in 64 mode (input `mode_64`).
- R13: Unused bits, unmapped addresses and every cycle without a read strobe return 8'h00 on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Host address |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, zero when not reading |
| sw_speed_normal | input | 1 | Hardware speed switch, 1 = normal |
| sw_dos_rom | input | 1 | Disk-ROM switch state |
| host_fast | input | 1 | Host fast bit, selects 2 MHz in normal speed |
| mode_64 | input | 1 | 1 when the host runs in 64 mode |
| speed_sel | output | 2 | 00 = 1 MHz, 01 = 2 MHz, 10 = turbo |
| opt_mode | output | 2 | Optimization mode select |
| hwreg_en | output | 1 | Hardware-register-enable latch |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle. They also assume that the switch and mode inputs are stable, synchronous levels, so a strobe decodes to at most one write event. The stimulus issues single-cycle bus operations with idle cycles between them. It changes the external inputs only after a clock edge and never while a strobe is high. A behavioural model mirrors each write and compares every output on every cycle.

// File: rtl/acr_pkg.sv
package acr_pkg;

  localparam int unsigned OPT_N = 4;

  // low-byte offsets inside the decoded page
  localparam logic [7:0] OFS_GO_NORMAL   = 8'h7A;
  localparam logic [7:0] OFS_GO_TURBO    = 8'h7B;
  localparam logic [7:0] OFS_GO_TURBO_B  = 8'h79;
  localparam logic [7:0] OFS_EN_SET      = 8'h7E;
  localparam logic [7:0] OFS_EN_CLR      = 8'h7F;
  localparam logic [7:0] OFS_EN_CLR_B    = 8'h7D;
  localparam logic [7:0] OFS_OPT_BASE    = 8'h74;
  localparam logic [7:0] OFS_MODE_ID     = 8'hB0;
  localparam logic [7:0] OFS_FLAGS       = 8'hB2;
  localparam logic [7:0] OFS_OPT_REG     = 8'hB4;
  localparam logic [7:0] OFS_SWITCHES    = 8'hB5;
  localparam logic [7:0] OFS_SPEED_REG   = 8'hB8;

  typedef enum logic [1:0] {
    OPT_VID_HI  = 2'b00,
    OPT_VID_LO  = 2'b01,
    OPT_TEXT    = 2'b10,
    OPT_NONE    = 2'b11
  } opt_mode_e;

  typedef enum logic [1:0] {
    SPD_SLOW      = 2'b00,
    SPD_HOST_FAST = 2'b01,
    SPD_TURBO     = 2'b10
  } speed_e;

  typedef struct packed {
    logic             go_normal;
    logic             go_turbo;
    logic             en_set;
    logic             en_clr;
    logic [OPT_N-1:0] opt_pick;
    logic             wr_flags;
    logic             wr_opt;
    logic             wr_speed;
  } wr_ev_t;

  // speed code chosen from the forced-normal condition and host fast bit
  function automatic logic [1:0] speed_pick(input logic forced_normal,
                                            input logic fast_bit);
    logic [1:0] r;
    if (forced_normal) r = fast_bit ? SPD_HOST_FAST : SPD_SLOW;
    else               r = SPD_TURBO;
    return r;
  endfunction

  // forced-normal condition: any source asking for normal speed
  function automatic logic forced_normal(input logic soft_normal,
                                         input logic switch_normal,
                                         input logic slow_flag);
    return soft_normal | switch_normal | slow_flag;
  endfunction

  // two flags placed in bits 7:6, rest zero
  function automatic logic [7:0] pack_hi2(input logic b7, input logic b6);
    return {b7, b6, 6'b000000};
  endfunction

endpackage

// File: rtl/acr_wr_decode.sv
module acr_wr_decode
  import acr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-9:0] PAGE = (ADDR_W-8)'(8'hD0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  output wr_ev_t            ev
);

  localparam int unsigned LO_W = 8;

  logic            in_page;
  logic [LO_W-1:0] lo;
  logic [OPT_N-1:0] opt_hit;

  assign in_page = bus_wr && (bus_addr[ADDR_W-1:LO_W] == PAGE);
  assign lo      = bus_addr[LO_W-1:0];

  generate
    for (genvar k = 0; k < OPT_N; k++) begin : g_opt
      assign opt_hit[k] = in_page && (lo == OFS_OPT_BASE + LO_W'(k));
    end
  endgenerate

  always_comb begin
    ev           = '0;
    ev.go_normal = in_page && (lo == OFS_GO_NORMAL);
    ev.go_turbo  = in_page && ((lo == OFS_GO_TURBO) || (lo == OFS_GO_TURBO_B));
    ev.en_set    = in_page && (lo == OFS_EN_SET);
    ev.en_clr    = in_page && ((lo == OFS_EN_CLR) || (lo == OFS_EN_CLR_B));
    ev.opt_pick  = opt_hit;
    ev.wr_flags  = in_page && (lo == OFS_FLAGS);
    ev.wr_opt    = in_page && (lo == OFS_OPT_REG);
    ev.wr_speed  = in_page && (lo == OFS_SPEED_REG);
  end

  // one address selects at most one action (R5, R6)
  p_single_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev));

  p_no_event_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> (ev == '0));

endmodule

// File: rtl/acr_ctl_state.sv
module acr_ctl_state
  import acr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wr_ev_t     ev,
  input  logic [7:0] bus_wdata,
  output logic       hwreg_en,
  output logic       soft_normal,
  output logic       slow_flag,
  output logic [1:0] opt_mode
);

  logic [1:0] opt_from_strobe;
  logic       any_opt_strobe;

  always_comb begin
    opt_from_strobe = opt_mode;
    for (int k = 0; k < OPT_N; k++) begin
      if (ev.opt_pick[k]) opt_from_strobe = 2'(k);
    end
  end
  assign any_opt_strobe = |ev.opt_pick;

  // enable latch
  always_ff @(posedge clk) begin
    if (!rst_n)         hwreg_en <= 1'b0;
    else if (ev.en_set) hwreg_en <= 1'b1;
    else if (ev.en_clr) hwreg_en <= 1'b0;
  end

  // software speed flag: strobes act always, register write needs enable
  always_ff @(posedge clk) begin
    if (!rst_n)                        soft_normal <= 1'b0;
    else if (ev.go_normal)             soft_normal <= 1'b1;
    else if (ev.go_turbo)              soft_normal <= 1'b0;
    else if (ev.wr_speed && hwreg_en)  soft_normal <= bus_wdata[7];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        slow_flag <= 1'b0;
    else if (ev.wr_flags && hwreg_en)  slow_flag <= bus_wdata[6];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           opt_mode <= OPT_NONE;
    else if (hwreg_en && any_opt_strobe)  opt_mode <= opt_from_strobe;
    else if (hwreg_en && ev.wr_opt)       opt_mode <= bus_wdata[7:6];
  end

  p_go_normal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev.go_normal |=> soft_normal);

  p_go_turbo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev.go_turbo |=> !soft_normal);

  p_strobe_when_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.go_normal && !hwreg_en) |=> soft_normal);

  p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev.en_set |=> hwreg_en);

  p_en_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev.en_clr |=> !hwreg_en);

  p_opt_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hwreg_en |=> $stable(opt_mode));

  p_opt_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hwreg_en && ev.opt_pick[0]) |=> (opt_mode == OPT_VID_HI));

  p_slow_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hwreg_en |=> $stable(slow_flag));

  p_speed_reg_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hwreg_en && !ev.go_normal && !ev.go_turbo) |=> $stable(soft_normal));

endmodule

// File: rtl/acr_rd_mux.sv
module acr_rd_mux
  import acr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-9:0] PAGE = (ADDR_W-8)'(8'hD0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              hwreg_en,
  input  logic              soft_normal,
  input  logic              slow_flag,
  input  logic              force_norm,
  input  logic [1:0]        opt_mode,
  input  logic              sw_speed_normal,
  input  logic              sw_dos_rom,
  input  logic              mode_64,
  output logic [7:0]        bus_rdata
);

  logic       in_page;
  logic [7:0] sel_data;

  assign in_page = bus_addr[ADDR_W-1:8] == PAGE;

  always_comb begin
    unique case (bus_addr[7:0])
      OFS_MODE_ID:   sel_data = pack_hi2(1'b0, mode_64);
      OFS_FLAGS:     sel_data = pack_hi2(hwreg_en, slow_flag);
      OFS_OPT_REG:   sel_data = pack_hi2(opt_mode[1], opt_mode[0]);
      OFS_SWITCHES:  sel_data = pack_hi2(sw_dos_rom, sw_speed_normal);
      OFS_SPEED_REG: sel_data = pack_hi2(soft_normal, force_norm);
      default:       sel_data = 8'h00;
    endcase
  end

  assign bus_rdata = (bus_rd && in_page) ? sel_data : 8'h00;

  p_idle_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));

  p_low_bits_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[5:0] == 6'b000000);

endmodule

// File: rtl/accel_ctl_regs.sv
module accel_ctl_regs
  import acr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-9:0] PAGE = (ADDR_W-8)'(8'hD0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [7:0]        bus_rdata,
  input  logic              sw_speed_normal,
  input  logic              sw_dos_rom,
  input  logic              host_fast,
  input  logic              mode_64,
  output logic [1:0]        speed_sel,
  output logic [1:0]        opt_mode,
  output logic              hwreg_en
);

  wr_ev_t wr_ev;
  logic   soft_normal;
  logic   slow_flag;
  logic   force_norm;

  acr_wr_decode #(.ADDR_W(ADDR_W), .PAGE(PAGE)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .ev       (wr_ev)
  );

  acr_ctl_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev          (wr_ev),
    .bus_wdata   (bus_wdata),
    .hwreg_en    (hwreg_en),
    .soft_normal (soft_normal),
    .slow_flag   (slow_flag),
    .opt_mode    (opt_mode)
  );

  assign force_norm = forced_normal(soft_normal, sw_speed_normal, slow_flag);
  assign speed_sel  = speed_pick(force_norm, host_fast);

  acr_rd_mux #(.ADDR_W(ADDR_W), .PAGE(PAGE)) u_rd (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_rd          (bus_rd),
    .hwreg_en        (hwreg_en),
    .soft_normal     (soft_normal),
    .slow_flag       (slow_flag),
    .force_norm      (force_norm),
    .opt_mode        (opt_mode),
    .sw_speed_normal (sw_speed_normal),
    .sw_dos_rom      (sw_dos_rom),
    .mode_64         (mode_64),
    .bus_rdata       (bus_rdata)
  );

  p_switch_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_speed_normal |-> (speed_sel == {1'b0, host_fast}));

  p_turbo_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_speed_normal && !soft_normal && !slow_flag) |-> (speed_sel == SPD_TURBO));

  p_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    speed_sel != 2'b11);

  p_no_rdwr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

endmodule

// File: tb/sim_accel_ctl_regs.sv
`timescale 1ns/1ps
module sim_accel_ctl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_rdata;
  logic        sw_speed_normal = 1'b0;
  logic        sw_dos_rom = 1'b0;
  logic        host_fast = 1'b0;
  logic        mode_64 = 1'b0;
  logic [1:0]  speed_sel;
  logic [1:0]  opt_mode;
  logic        hwreg_en;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit       m_en;
  bit       m_norm;
  bit       m_slow;
  bit [1:0] m_opt;

  always #2.5 clk = ~clk;

  accel_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .sw_speed_normal(sw_speed_normal), .sw_dos_rom(sw_dos_rom),
    .host_fast(host_fast), .mode_64(mode_64),
    .speed_sel(speed_sel), .opt_mode(opt_mode), .hwreg_en(hwreg_en)
  );

  function automatic bit forced();
    return m_norm || sw_speed_normal || m_slow;
  endfunction

  function automatic logic [1:0] exp_speed();
    if (forced()) return host_fast ? 2'd1 : 2'd0;
    return 2'd2;
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    logic [7:0] v;
    v = 8'h00;
    if (a == 16'hD0B0) v[6] = mode_64;
    if (a == 16'hD0B2) v = {m_en, m_slow, 6'd0};
    if (a == 16'hD0B4) v = {m_opt, 6'd0};
    if (a == 16'hD0B5) v = {sw_dos_rom, sw_speed_normal, 6'd0};
    if (a == 16'hD0B8) v = {m_norm, forced(), 6'd0};
    return v;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7 speed_sel", {6'd0, speed_sel}, {6'd0, exp_speed()});
      check("R6 opt_mode", {6'd0, opt_mode}, {6'd0, m_opt});
      check("R5 hwreg_en", {7'd0, hwreg_en}, {7'd0, m_en});
      if (!bus_rd) check("R13 idle rdata", bus_rdata, 8'h00);
    end
  end

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    if (a == 16'hD07A) m_norm = 1'b1;
    else if (a == 16'hD07B || a == 16'hD079) m_norm = 1'b0;
    else if (a == 16'hD07E) m_en = 1'b1;
    else if (a == 16'hD07F || a == 16'hD07D) m_en = 1'b0;
    else if (a >= 16'hD074 && a <= 16'hD077) begin
      if (m_en) m_opt = 2'(a - 16'hD074);
    end
    else if (a == 16'hD0B2) begin if (m_en) m_slow = d[6]; end
    else if (a == 16'hD0B4) begin if (m_en) m_opt = d[7:6]; end
    else if (a == 16'hD0B8) begin if (m_en) m_norm = d[7]; end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(tag, bus_rdata, exp_read(a));
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic set_in(input bit swn, input bit dos, input bit fast, input bit m64);
    @(posedge clk); #1;
    sw_speed_normal = swn; sw_dos_rom = dos; host_fast = fast; mode_64 = m64;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_en = 0; m_norm = 0; m_slow = 0; m_opt = 2'b11;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check("R1 hwreg_en", {7'd0, hwreg_en}, 8'h00);
    check("R1 opt_mode", {6'd0, opt_mode}, 8'h03);
    check("R1 speed_sel turbo", {6'd0, speed_sel}, 8'h02);
    rd(16'hD0B2, "R1 flags");
    rd(16'hD0B8, "R1 speed reg");

    // R2 / R3 / R4 strobes with closed register group
    wr(16'hD07A, 8'h55); rd(16'hD0B8, "R2 normal strobe");
    wr(16'hD07B, 8'h00); rd(16'hD0B8, "R3 turbo strobe");
    wr(16'hD07A, 8'hFF); wr(16'hD079, 8'hFF); rd(16'hD0B8, "R3 turbo duplicate");
    wr(16'hD07A, 8'h00); rd(16'hD0B8, "R4 strobe while closed");

    // R7 host fast bit and switch priority
    set_in(0, 0, 1, 0); rd(16'hD0B8, "R7 normal at 2MHz");
    wr(16'hD07B, 8'h12);
    set_in(1, 0, 0, 0); rd(16'hD0B8, "R7 switch forces normal");
    set_in(1, 0, 1, 0); wr(16'hD07B, 8'h00); rd(16'hD0B8, "R7 turbo blocked by switch");
    set_in(0, 0, 0, 0);

    // R6 optimization strobes ignored while closed
    for (int k = 0; k < 4; k++) wr(16'hD074 + 16'(k), 8'h00);
    rd(16'hD0B4, "R6 ignored while closed");
    wr(16'hD0B4, 8'h00); rd(16'hD0B4, "R9 write ignored while closed");
    wr(16'hD0B2, 8'h40); rd(16'hD0B2, "R8 write ignored while closed");
    wr(16'hD0B8, 8'h80); rd(16'hD0B8, "R11 write ignored while closed");

    // R5 open the group
    wr(16'hD07E, 8'h00); rd(16'hD0B2, "R5 enable set");
    for (int k = 0; k < 4; k++) begin
      wr(16'hD074 + 16'(k), 8'hA5);
      rd(16'hD0B4, "R6 strobe while open");
    end
    wr(16'hD074, 8'h00);
    wr(16'hD0B4, 8'h80); rd(16'hD0B4, "R9 write while open");
    wr(16'hD0B4, 8'h7F); rd(16'hD0B4, "R9 write bits 7:6");

    // R8 slow flag forces normal (R7)
    wr(16'hD0B2, 8'h40); rd(16'hD0B2, "R8 slow flag set");
    rd(16'hD0B8, "R7 slow flag forces normal");
    wr(16'hD0B2, 8'h80); rd(16'hD0B2, "R8 slow flag cleared");

    // R11 speed register write while open, R4 strobes while open
    wr(16'hD0B8, 8'h80); rd(16'hD0B8, "R11 write normal");
    wr(16'hD0B8, 8'h7F); rd(16'hD0B8, "R11 write turbo");
    wr(16'hD07A, 8'h00); rd(16'hD0B8, "R4 strobe while open");
    wr(16'hD07B, 8'h00);

    // R10 switch register, write has no effect
    set_in(0, 1, 0, 0); rd(16'hD0B5, "R10 dos switch");
    wr(16'hD0B5, 8'hFF); rd(16'hD0B5, "R10 write no effect");
    set_in(1, 0, 0, 0); rd(16'hD0B5, "R10 speed switch");
    wr(16'hD0B5, 8'h00); rd(16'hD0B5, "R10 write no effect 2");
    set_in(0, 0, 0, 0);

    // R12 mode detect
    rd(16'hD0B0, "R12 128 mode");
    set_in(0, 0, 0, 1); rd(16'hD0B0, "R12 64 mode");
    wr(16'hD0B0, 8'hFF); rd(16'hD0B0, "R12 after write");

    // R5 close via both addresses
    wr(16'hD07F, 8'h00); rd(16'hD0B2, "R5 enable clear");
    wr(16'hD07E, 8'h00); wr(16'hD07D, 8'hFF); rd(16'hD0B2, "R5 clear duplicate");
    wr(16'hD075, 8'h00); rd(16'hD0B4, "R6 ignored after close");

    // R13 unmapped addresses
    rd(16'hD0B1, "R13 unmapped B1");
    rd(16'hD0FF, "R13 unmapped FF");
    rd(16'hC0B2, "R13 other page");
    rd(16'hD07A, "R13 strobe address reads zero");

    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule